// File: doc/BRIEF.md
# Serial Codec Control Word Sequencer

This block is the host side of a codec's serial data port. It takes one parallel word per transfer, a DAC sample in the upper bits and a control code in the lowest two bits, and shifts it out MSB first on a single data line. An active-low transmit frame marks every bit of the word. Bit timing comes from a one-cycle shift enable, which is the serial bit clock reduced to a system-clock strobe. An upstream source offers words with a valid/ready handshake.

When the control code is all ones, the block sends a secondary configuration word after the primary one. Between the two words the transmit frame stays high for a fixed number of shift periods. The receive frame marks primary words only. When the dual-word option is set, the dual frame marks secondary words only. A byte mode sends each word as two 8-bit frames, for hosts with 8-bit serial ports. The data source cannot start a new primary word until any pending secondary word has left the line, so the sample rate never drops a DAC value.

Top module: `codec_word_tx`

## Requirements
- R1: After a synchronous reset, `tx_frame_n`, `rx_frame_n` and `dw_frame_n` are 1, `tx_data` is 0 and `word_ready` is 1.
- R2: A word is accepted on a clock edge where `word_valid` and `word_ready` are both 1. On the first shift tick after that, `tx_frame_n` falls and `tx_data` carries bit 15. Each later tick presents the next lower bit, so bit 0 is on the line during the sixteenth tick period.
- R3: `word_ready` is 0 from the accepting edge until the tick that ends the last frame of the transfer. A `word_valid` pulse while `word_ready` is 0 starts nothing.
- R4: With `byte_mode` at 1, the word is sent as two frames of 8 ticks each, bits 15..8 and then bits 7..0, with one tick of `tx_frame_n` high between them. Bits 1..0 of the second byte are sent as 0.
- R5: When `word_data[1:0]` is 11, `tx_frame_n` stays high for exactly 4 tick periods after the primary word and then falls to start the secondary word.
- R6: With a control code of 00, 01 or 10, no secondary word follows. All frames are high on the tick after the last primary bit, and `word_ready` returns to 1.
- R7: `rx_frame_n` is 0 exactly during primary-word bit periods and never during a secondary word.
- R8: With `dual_mode` at 1, `dw_frame_n` is 0 exactly during secondary-word bit periods. With `dual_mode` at 0 it stays 1.
- R9: The secondary word uses the same bit timing as the primary word. It is sampled from `sec_data` at acceptance, sent MSB first, and split into bytes with bits 1..0 zeroed when `byte_mode` is 1.
- R10: `tx_data` is 0 whenever `tx_frame_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | One-cycle strobe per serial bit period |
| word_valid | input | 1 | Word offered |
| word_data | input | 16 | Primary word: sample in 15..2, control code in 1..0 |
| sec_data | input | 16 | Secondary configuration word |
| byte_mode | input | 1 | Send as two 8-bit frames (sampled at acceptance) |
| dual_mode | input | 1 | Enable the dual frame for secondary words (sampled at acceptance) |
| word_ready | output | 1 | Block idle, can accept a word |
| tx_data | output | 1 | Serial data, MSB first |
| tx_frame_n | output | 1 | Active-low transmit frame |
| rx_frame_n | output | 1 | Active-low receive frame, primary words only |
| dw_frame_n | output | 1 | Active-low dual frame, secondary words only |

## Verification
A wrong bit counter shows on the very next tick as a frame that is one period too long or too short. A stuck or wrong word-type flag shows as `rx_frame_n` or `dw_frame_n` falling in the wrong word, which is visible during the first bit period of a secondary word. A wrong gap counter moves the secondary frame's falling edge off the fourth tick after the primary word. The bench compares all four serial outputs on every tick against a per-tick expected stream. A single-tick slip therefore shows up as a mismatch within one shift period.

// File: rtl/codec_tx_pkg.sv
package codec_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_BIT,
    ST_BGAP,
    ST_SGAP
  } seq_state_t;
endpackage

// File: rtl/codec_tx_seq.sv
module codec_tx_seq
  import codec_tx_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int GAP_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shift_en,
  input  logic       accept,
  input  logic       req_sec,
  input  logic       byte_mode,
  input  logic       dual_mode,
  output logic       emit,
  output logic       start_sec,
  output logic       nxt_bit,
  output logic       nxt_sec,
  output logic       dual_q,
  output logic       idle
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int GAP_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_W - 1);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_TICKS - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             half_q, half_d;
  logic             sec_q, sec_d;
  logic             bm_q, req_q;
  logic [CNT_W-1:0] unit_last;

  assign unit_last = bm_q ? LAST_BYTE : LAST_WORD;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    gap_d     = gap_q;
    half_d    = half_q;
    sec_d     = sec_q;
    emit      = 1'b0;
    start_sec = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_ARM;
      ST_ARM: if (shift_en) begin
        state_d = ST_BIT;
        cnt_d   = unit_last;
        half_d  = 1'b0;
        sec_d   = 1'b0;
        emit    = 1'b1;
      end
      ST_BIT: if (shift_en) begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
          emit  = 1'b1;
        end else if (bm_q && !half_q) begin
          state_d = ST_BGAP;
          half_d  = 1'b1;
        end else if (!sec_q && req_q) begin
          state_d = ST_SGAP;
          gap_d   = GAP_LAST;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_BGAP: if (shift_en) begin
        state_d = ST_BIT;
        cnt_d   = LAST_BYTE;
        emit    = 1'b1;
      end
      ST_SGAP: if (shift_en) begin
        if (gap_q != '0) begin
          gap_d = gap_q - 1'b1;
        end else begin
          state_d   = ST_BIT;
          cnt_d     = unit_last;
          half_d    = 1'b0;
          sec_d     = 1'b1;
          start_sec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      half_q  <= 1'b0;
      sec_q   <= 1'b0;
      bm_q    <= 1'b0;
      req_q   <= 1'b0;
      dual_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
      half_q  <= half_d;
      sec_q   <= sec_d;
      if (accept) begin
        bm_q   <= byte_mode;
        req_q  <= req_sec;
        dual_q <= dual_mode;
      end
    end
  end

  assign nxt_bit = (state_d == ST_BIT);
  assign nxt_sec = sec_d;
  assign idle    = (state_q == ST_IDLE);

  // R5: a secondary gap is only ever entered from a primary word
  assert_gap_after_primary_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SGAP) |-> !sec_q);
  // R3: acceptance only while idle
  assert_accept_idle_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state_q == ST_ARM));
endmodule

// File: rtl/codec_tx_shift.sv
module codec_tx_shift #(
  parameter int WORD_W = 16,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              load,
  input  logic              byte_mode,
  input  logic [WORD_W-1:0] pri_word,
  input  logic [WORD_W-1:0] sec_word,
  input  logic              emit,
  input  logic              start_sec,
  output logic              tx_data
);
  logic [WORD_W-1:0] sreg_q, sec_q;
  logic [WORD_W-1:0] pri_line, sec_line;

  function automatic logic [WORD_W-1:0] line_word(input logic [WORD_W-1:0] w,
                                                  input logic bm);
    logic [WORD_W-1:0] r;
    r = w;
    if (bm) r[CTRL_W-1:0] = '0;
    return r;
  endfunction

  assign pri_line = line_word(pri_word, byte_mode);
  assign sec_line = line_word(sec_word, byte_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q  <= '0;
      sec_q   <= '0;
      tx_data <= 1'b0;
    end else begin
      if (load) begin
        sreg_q <= pri_line;
        sec_q  <= sec_line;
      end
      if (start_sec) begin
        tx_data <= sec_q[WORD_W-1];
        sreg_q  <= {sec_q[WORD_W-2:0], 1'b0};
      end else if (emit) begin
        tx_data <= sreg_q[WORD_W-1];
        sreg_q  <= {sreg_q[WORD_W-2:0], 1'b0};
      end else if (shift_en) begin
        tx_data <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/codec_tx_frames.sv
module codec_tx_frames (
  input  logic clk,
  input  logic rst,
  input  logic nxt_bit,
  input  logic nxt_sec,
  input  logic dual,
  output logic tx_frame_n,
  output logic rx_frame_n,
  output logic dw_frame_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_frame_n <= 1'b1;
      rx_frame_n <= 1'b1;
      dw_frame_n <= 1'b1;
    end else begin
      tx_frame_n <= !nxt_bit;
      rx_frame_n <= !(nxt_bit && !nxt_sec);
      dw_frame_n <= !(nxt_bit && nxt_sec && dual);
    end
  end

  // R7: receive frame only inside a transmit frame
  assert_rx_inside_tx_R7: assert property (@(posedge clk) disable iff (rst)
    !rx_frame_n |-> !tx_frame_n);
  // R8: dual frame and receive frame never overlap
  assert_dw_excludes_rx_R8: assert property (@(posedge clk) disable iff (rst)
    !dw_frame_n |-> rx_frame_n);
endmodule

// File: rtl/codec_word_tx.sv
module codec_word_tx #(
  parameter int WORD_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int CTRL_W    = 2,
  parameter int GAP_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic [WORD_W-1:0] sec_data,
  input  logic              byte_mode,
  input  logic              dual_mode,
  output logic              word_ready,
  output logic              tx_data,
  output logic              tx_frame_n,
  output logic              rx_frame_n,
  output logic              dw_frame_n
);
  logic accept, req_sec, emit, start_sec, nxt_bit, nxt_sec, dual_q, idle;

  assign word_ready = idle;
  assign accept     = word_valid && idle;
  assign req_sec    = &word_data[CTRL_W-1:0];

  codec_tx_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .GAP_TICKS(GAP_TICKS)) u_seq (
    .clk(clk), .rst(rst), .shift_en(shift_en), .accept(accept),
    .req_sec(req_sec), .byte_mode(byte_mode), .dual_mode(dual_mode),
    .emit(emit), .start_sec(start_sec), .nxt_bit(nxt_bit), .nxt_sec(nxt_sec),
    .dual_q(dual_q), .idle(idle));

  codec_tx_shift #(.WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .load(accept),
    .byte_mode(byte_mode), .pri_word(word_data), .sec_word(sec_data),
    .emit(emit), .start_sec(start_sec), .tx_data(tx_data));

  codec_tx_frames u_frames (
    .clk(clk), .rst(rst), .nxt_bit(nxt_bit), .nxt_sec(nxt_sec), .dual(dual_q),
    .tx_frame_n(tx_frame_n), .rx_frame_n(rx_frame_n), .dw_frame_n(dw_frame_n));

  // R3: no new word is taken while a frame is on the line
  assert_busy_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    !tx_frame_n |-> !word_ready);
  // R10: data line quiet outside frames
  assert_quiet_data_R10: assert property (@(posedge clk) disable iff (rst)
    tx_frame_n |-> !tx_data);
  // R2: the frame never starts on the accepting edge
  assert_arm_before_frame_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> tx_frame_n);
endmodule

// File: tb/test_codec_word_tx.sv
module test_codec_word_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic [15:0] sec_data = '0;
  logic        byte_mode = 1'b0;
  logic        dual_mode = 1'b0;
  logic        shift_en;
  logic        word_ready, tx_data, tx_frame_n, rx_frame_n, dw_frame_n;
  logic [1:0]  div = '0;

  typedef struct {
    logic [3:0] v;    // {tx_frame_n, rx_frame_n, dw_frame_n, tx_data}
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   compared = 0;
  int   mismatched = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) div <= div + 2'd1;
  assign shift_en = (div == 2'd0);

  codec_word_tx i_codec_word_tx (
    .clk(clk), .rst(rst), .shift_en(shift_en), .word_valid(word_valid),
    .word_data(word_data), .sec_data(sec_data), .byte_mode(byte_mode),
    .dual_mode(dual_mode), .word_ready(word_ready), .tx_data(tx_data),
    .tx_frame_n(tx_frame_n), .rx_frame_n(rx_frame_n), .dw_frame_n(dw_frame_n));

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {txf,rxf,dwf,d} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares every tick against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      if (shift_en && !rst) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check({tx_frame_n, rx_frame_n, dw_frame_n, tx_data}, e.v, e.req);
        end else begin
          check({tx_frame_n, rx_frame_n, dw_frame_n, tx_data}, 4'b1110, "R6/R10 idle");
        end
      end
    end
  end

  task automatic push(input logic [3:0] v, input string req);
    exp_t e;
    e.v = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // push one word's worth of bit periods (primary or secondary)
  task automatic push_word(input logic [15:0] w, input bit bm, input bit sec, input bit dm);
    logic [15:0] lw;
    logic [2:0]  fr;
    lw = w;
    if (bm) lw[1:0] = 2'b00;                        // R4 / R9
    fr = sec ? {1'b0, 1'b1, !dm} : 3'b001;          // R7 / R8
    for (int i = 15; i >= 0; i--) begin
      push({fr, lw[i]}, sec ? "R9 secondary bit" : "R2 primary bit");
      if (bm && i == 8) push(4'b1110, "R4 byte gap");
    end
  endtask

  task automatic send(input logic [15:0] pw, input logic [15:0] sw,
                      input bit bm, input bit dm);
    @(negedge clk);
    while (!word_ready || shift_en) @(negedge clk);
    push_word(pw, bm, 1'b0, dm);
    if (pw[1:0] == 2'b11) begin
      for (int g = 0; g < 4; g++) push(4'b1110, "R5 secondary gap");
      push_word(sw, bm, 1'b1, dm);
    end
    word_data  = pw;
    sec_data   = sw;
    byte_mode  = bm;
    dual_mode  = dm;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    word_data  = 16'hFFFF;
    sec_data   = 16'h0000;
    byte_mode  = !bm;
    dual_mode  = !dm;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check({tx_frame_n, rx_frame_n, dw_frame_n, tx_data}, 4'b1110, "R1 frames");
    check({3'b000, word_ready}, 4'b0001, "R1 ready");

    send(16'hA5A4, 16'h0000, 0, 0);   // R6 code 00
    drain();
    send(16'h3C35, 16'h0000, 0, 1);   // R6 code 01
    drain();
    send(16'hC3CA, 16'h0000, 0, 1);   // R6 code 10
    drain();
    send(16'h9A5B, 16'h6E81, 0, 0);   // R5 secondary, dual off
    drain();
    send(16'h4D27, 16'hB35C, 0, 1);   // R8 secondary, dual on
    drain();
    send(16'hF00F, 16'h0000, 1, 0);   // R4 byte mode, code 11 zeroed -> secondary
    drain();
    send(16'h81FE, 16'h7FFF, 1, 1);   // R4/R9 byte mode, code 10
    drain();
    send(16'hFFFF, 16'hFFFF, 1, 1);   // R9 byte mode secondary with zeroed bits
    drain();

    // R3: busy hold-off and ignored valid
    send(16'h1234, 16'h0000, 0, 0);
    repeat (3) @(negedge clk);
    check({3'b000, word_ready}, 4'b0000, "R3 busy");
    word_data = 16'hFFFF;
    word_valid = 1'b1;
    repeat (8) @(negedge clk);
    word_valid = 1'b0;
    check({3'b000, word_ready}, 4'b0000, "R3 still busy");
    drain();
    check({3'b000, word_ready}, 4'b0001, "R3 ready again");
    send(16'hFFFF, 16'h0001, 0, 1);   // all ones primary, secondary LSB
    drain();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule